// File: doc/BRIEF.md
# Two-Level Hardware Page Table Walker

When a translation buffer misses, this block looks up the missing mapping in a two-level page table. The table sits in physical memory that is read without translation. The walker takes a 20-bit virtual page number and the physical base address of the current top-level table. It forms the top-level entry address and reads that entry through a single memory read port. A present top-level entry names the physical page that holds the second-level table. The walker then reads the leaf entry from that table. It returns the physical page number and the read, write and user permissions, which are used to refill the translation buffer.

If the entry at either level is not present, the walk stops at once. The walker then reports a page fault for the original access. The walker keeps exactly one memory read in flight. It takes a new miss only while idle, and it holds its result until the consumer accepts it.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `busy` is 0, `miss_ready` is 1, `mem_req_valid` is 0 and `res_valid` is 0.
- R2: The first read of a walk goes to `root + 4 * vpn[19:10]`, where vpn[19:10] is virtual address bits 31:22.
- R3: Every entry is 32 bits wide. Bit 0 is present, bit 1 is read, bit 2 is write, bit 3 is user, and bits 31:12 hold the physical page number. The second read goes to `(top-level entry bits 31:12) << 12` plus `4 * vpn[9:0]`.
- R4: A present leaf gives one result with `res_fault`=0. The result carries the request's vpn, the leaf's page number and the leaf's read, write and user bits.
- R5: A top-level entry whose bit 0 is clear ends the walk after a single read. The result has `res_fault`=1, a page number of 0 and all permission bits at 0, whatever the entry's other bits are.
- R6: A leaf whose bit 0 is clear gives a fault result after exactly two reads, with a page number of 0 and all permission bits at 0.
- R7: At most one memory read is outstanding. A read request stays asserted, with a stable address, until it is accepted.
- R8: A miss is accepted only while idle. `miss_ready` stays 0 while busy, and a miss offered while busy has no effect on the walk in progress or on its result.
- R9: `busy` goes high in the cycle after a miss is accepted. It stays high until the cycle after the result handshake.
- R10: While `res_valid` is high and `res_ready` is low, every result field holds its value.
- R11: A memory response that arrives while no read is outstanding is ignored.
- R12: The root base is sampled when the miss is accepted. Later changes to it do not affect the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request offered |
| miss_ready | output | 1 | Walker idle and able to accept a miss |
| miss_vpn | input | 20 | Virtual page number of the missing access |
| root_base | input | 32 | Physical base of the top-level table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word returned |
| res_valid | output | 1 | Walk result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_vpn | output | 20 | Virtual page number of the walk |
| res_ppn | output | 20 | Physical page number of the leaf |
| res_read | output | 1 | Leaf grants read |
| res_write | output | 1 | Leaf grants write |
| res_user | output | 1 | Leaf grants user access |
| res_fault | output | 1 | Page fault: a non-present entry was found |
| busy | output | 1 | A walk is in progress or its result is pending |

## Verification
The in-design properties check the handshake discipline on every cycle:

- no second read after one is accepted;
- a pending read and a pending result hold steady;
- a read and a result are never offered together;
- `busy` rises after acceptance and falls after the result handshake;
- fault results carry zeroed page number and permissions.

Only the directed scenarios can show the rest. They confirm that the computed entry addresses, the page number and permission extraction, and the abort after the first or second level match the table contents. They also show that stray responses, misses offered while busy and a changing root base leave the result untouched.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
    parameter int VA_W  = 32;
    parameter int PA_W  = 32;
    parameter int OFF_W = 12;
    parameter int IDX_W = 10;
    parameter int PTE_W = 32;

    localparam int VPN_W     = VA_W - OFF_W;
    localparam int PPN_W     = PA_W - OFF_W;
    localparam int PTE_BYTES = PTE_W / 8;
    localparam int PTE_SHIFT = $clog2(PTE_BYTES);

    localparam int PTE_P_BIT = 0;
    localparam int PTE_R_BIT = 1;
    localparam int PTE_W_BIT = 2;
    localparam int PTE_U_BIT = 3;
    localparam int FLAG_W    = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef struct packed {
        logic user;
        logic write;
        logic read;
    } perm_t;

    typedef struct packed {
        logic             present;
        perm_t            perm;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    typedef struct packed {
        walk_state_e      state;
        logic [VPN_W-1:0] vpn;
        logic [PA_W-1:0]  tbl_base;
        logic [PPN_W-1:0] ppn;
        perm_t            perm;
    } walk_t;
endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr
    import pgwalk_pkg::*;
#(
    parameter int BASE_W = PA_W,
    parameter int IW     = IDX_W,
    parameter int SH     = PTE_SHIFT
) (
    input  logic [BASE_W-1:0] base,
    input  logic [IW-1:0]     idx,
    output logic [BASE_W-1:0] addr
);
    localparam int PAD_W = BASE_W - IW - SH;

    // Entry address: table base plus the index scaled by the entry size.
    assign addr = base + {{PAD_W{1'b0}}, idx, {SH{1'b0}}};
endmodule

// File: rtl/pgwalk_pte_dec.sv
module pgwalk_pte_dec
    import pgwalk_pkg::*;
(
    input  logic [PTE_W-1:0] word,
    output pte_t             fields
);
    logic unused_rsvd;

    assign fields.present    = word[PTE_P_BIT];
    assign fields.perm.read  = word[PTE_R_BIT];
    assign fields.perm.write = word[PTE_W_BIT];
    assign fields.perm.user  = word[PTE_U_BIT];
    assign fields.ppn        = word[PTE_W-1 -: PPN_W];
    // Usage and software bits between the flags and the page number are not consumed.
    assign unused_rsvd       = ^word[PTE_W-PPN_W-1:FLAG_W];
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_valid,
    output logic             miss_ready,
    input  logic [VPN_W-1:0] miss_vpn,
    input  logic [PA_W-1:0]  root_base,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             res_valid,
    input  logic             res_ready,
    output logic [VPN_W-1:0] res_vpn,
    output logic [PPN_W-1:0] res_ppn,
    output logic             res_read,
    output logic             res_write,
    output logic             res_user,
    output logic             res_fault,
    output logic             busy
);
    walk_t            st_q, st_d;
    logic [IDX_W-1:0] idx_sel;
    pte_t             pte;

    // Level select: the second level uses the low index, the first the high one.
    assign idx_sel = (st_q.state == ST_L2_REQ) ? st_q.vpn[IDX_W-1:0]
                                               : st_q.vpn[VPN_W-1 -: IDX_W];

    pgwalk_addr #(.BASE_W(PA_W), .IW(IDX_W), .SH(PTE_SHIFT)) i_addr (
        .base (st_q.tbl_base),
        .idx  (idx_sel),
        .addr (mem_req_addr)
    );

    pgwalk_pte_dec i_dec (
        .word   (mem_rsp_data),
        .fields (pte)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            ST_IDLE: begin
                if (miss_valid) begin
                    st_d.state    = ST_L1_REQ;
                    st_d.vpn      = miss_vpn;
                    st_d.tbl_base = root_base;
                    st_d.ppn      = '0;
                    st_d.perm     = '0;
                end
            end
            ST_L1_REQ: begin
                if (mem_req_ready) st_d.state = ST_L1_WAIT;
            end
            ST_L1_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!pte.present) begin
                        st_d.state = ST_FAULT;
                    end else begin
                        st_d.state    = ST_L2_REQ;
                        st_d.tbl_base = {pte.ppn, {OFF_W{1'b0}}};
                    end
                end
            end
            ST_L2_REQ: begin
                if (mem_req_ready) st_d.state = ST_L2_WAIT;
            end
            ST_L2_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!pte.present) begin
                        st_d.state = ST_FAULT;
                    end else begin
                        st_d.state = ST_DONE;
                        st_d.ppn   = pte.ppn;
                        st_d.perm  = pte.perm;
                    end
                end
            end
            ST_DONE, ST_FAULT: begin
                if (res_ready) st_d.state = ST_IDLE;
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign miss_ready    = (st_q.state == ST_IDLE);
    assign busy          = (st_q.state != ST_IDLE);
    assign mem_req_valid = (st_q.state == ST_L1_REQ) || (st_q.state == ST_L2_REQ);
    assign res_valid     = (st_q.state == ST_DONE) || (st_q.state == ST_FAULT);
    assign res_fault     = (st_q.state == ST_FAULT);
    assign res_vpn       = st_q.vpn;
    assign res_ppn       = st_q.ppn;
    assign res_read      = st_q.perm.read;
    assign res_write     = st_q.perm.write;
    assign res_user      = st_q.perm.user;

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R7
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R7
    AST_REQ_RES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid && res_valid)); // R7
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> busy); // R9
    AST_IDLE_AFTER_RES: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ready) |=> !busy); // R9
    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid &&
        $stable({res_vpn, res_ppn, res_read, res_write, res_user, res_fault}))); // R10
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> (res_ppn == '0 && !res_read && !res_write && !res_user)); // R5
endmodule

// File: tb/test_pgwalk_top.sv
module test_pgwalk_top;
    import pgwalk_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n;
    logic             miss_valid, miss_ready;
    logic [VPN_W-1:0] miss_vpn;
    logic [PA_W-1:0]  root_base;
    logic             mem_req_valid, mem_req_ready;
    logic [PA_W-1:0]  mem_req_addr;
    logic             mem_rsp_valid;
    logic [PTE_W-1:0] mem_rsp_data;
    logic             res_valid, res_ready;
    logic [VPN_W-1:0] res_vpn;
    logic [PPN_W-1:0] res_ppn;
    logic             res_read, res_write, res_user, res_fault, busy;

    pgwalk_top i_pgwalk_top (.*);

    int errors = 0;
    int checks = 0;

    // Memory model state
    logic [31:0] m_addr [8];
    logic [31:0] m_data [8];
    int          m_n = 0;
    logic [31:0] req_log [4];
    int          req_count = 0;
    int          lat = 0;
    int          rdy_delay = 0;
    int          spur_mode = 0;   // 1: fire while no request, 2: fire while request pending
    logic [31:0] spur_data = '0;
    bit          pend = 0;
    int          dly = 0;
    int          wait_cnt = 0;
    logic [31:0] paddr;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    function automatic logic [31:0] lookup(input logic [31:0] a);
        for (int i = 0; i < m_n; i++) if (m_addr[i] == a) return m_data[i];
        return 32'h0;
    endfunction

    task automatic mem_clear();
        m_n = 0;
    endtask

    task automatic mem_put(input logic [31:0] a, input logic [31:0] d);
        m_addr[m_n] = a;
        m_data[m_n] = d;
        m_n++;
    endtask

    // Memory responder: acts at each falling edge.
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (dly == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = lookup(paddr);
                    pend = 0;
                end else begin
                    dly--;
                end
            end else if ((spur_mode == 1 && !mem_req_valid) || (spur_mode == 2 && mem_req_valid)) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = spur_data;
                spur_mode = 0;
            end
            if (mem_req_valid && !pend) begin
                if (wait_cnt >= rdy_delay) begin
                    mem_req_ready = 1'b1;
                    paddr = mem_req_addr;
                    pend = 1;
                    dly = lat;
                    if (req_count < 4) req_log[req_count] = mem_req_addr;
                    req_count++;
                    wait_cnt = 0;
                end else begin
                    mem_req_ready = 1'b0;
                    wait_cnt++;
                end
            end else begin
                mem_req_ready = 1'b0;
            end
        end
    end

    int poke_bad = 0;

    // Offer a miss, change the root after acceptance, wait for the result (not yet accepted).
    task automatic do_walk(input logic [19:0] vpn, input logic [31:0] root, input bit poke);
        int t;
        req_count = 0;
        poke_bad = 0;
        miss_vpn = vpn;
        root_base = root;
        miss_valid = 1'b1;
        while (!miss_ready) @(negedge clk);
        @(negedge clk);
        miss_valid = 1'b0;
        root_base = root ^ 32'h00F0_0000;
        if (poke) begin
            miss_valid = 1'b1;
            miss_vpn = vpn ^ 20'hFFFFF;
        end
        t = 0;
        while (!res_valid && t < 200) begin
            if (miss_ready) poke_bad++;
            @(negedge clk);
            t++;
        end
        miss_valid = 1'b0;
    endtask

    task automatic take_result();
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
    endtask

    function automatic logic [31:0] l1_addr(input logic [31:0] root, input logic [19:0] vpn);
        return root + {20'h0, vpn[19:10], 2'b00};
    endfunction

    function automatic logic [31:0] l2_addr(input logic [31:0] l1w, input logic [19:0] vpn);
        return {l1w[31:12], 12'h0} + {20'h0, vpn[9:0], 2'b00};
    endfunction

    task automatic t_reset();
        chk("R1", "busy", {31'h0, busy}, 32'h0);
        chk("R1", "miss_ready", {31'h0, miss_ready}, 32'h1);
        chk("R1", "mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
        chk("R1", "res_valid", {31'h0, res_valid}, 32'h0);
    endtask

    task automatic leaf_case(input logic [19:0] vpn, input logic [31:0] root,
                             input logic [31:0] l1w, input logic [31:0] leaf);
        mem_clear();
        mem_put(l1_addr(root, vpn), l1w);
        mem_put(l2_addr(l1w, vpn), leaf);
        do_walk(vpn, root, 1'b0);
        chk("R2", "first read address", req_log[0], l1_addr(root, vpn));
        chk("R3", "second read address", req_log[1], l2_addr(l1w, vpn));
        chk("R4", "read count", req_count, 2);
        chk("R4", "res_fault", {31'h0, res_fault}, 32'h0);
        chk("R4", "res_vpn", {12'h0, res_vpn}, {12'h0, vpn});
        chk("R4", "res_ppn", {12'h0, res_ppn}, {12'h0, leaf[31:12]});
        chk("R3", "perm r/w/u", {29'h0, res_user, res_write, res_read}, {29'h0, leaf[3:1]});
        take_result();
    endtask

    task automatic t_leaf_walks();
        lat = 2; rdy_delay = 1;
        leaf_case(20'h12345, 32'h0010_0000, 32'h0020_0001, 32'hABCDE00F);
        lat = 0; rdy_delay = 0;
        leaf_case(20'hFFFFF, 32'h0FFF_F000, 32'h00ABC001, 32'h13579003);
        lat = 3; rdy_delay = 2;
        leaf_case(20'h00000, 32'h0000_0000, 32'h0000_1001, 32'h2468A00D);
    endtask

    task automatic t_l1_fault();
        logic [19:0] vpn = 20'h3C0A5;
        logic [31:0] root = 32'h0040_0000;
        lat = 1; rdy_delay = 0;
        mem_clear();
        mem_put(l1_addr(root, vpn), 32'h0020_000E);
        mem_put(l2_addr(32'h0020_000E, vpn), 32'hFFFFF00F);
        do_walk(vpn, root, 1'b0);
        chk("R5", "read count", req_count, 1);
        chk("R5", "res_fault", {31'h0, res_fault}, 32'h1);
        chk("R5", "res_ppn", {12'h0, res_ppn}, 32'h0);
        chk("R5", "perm", {29'h0, res_user, res_write, res_read}, 32'h0);
        take_result();
    endtask

    task automatic t_l2_fault();
        logic [19:0] vpn = 20'h0ABCD;
        logic [31:0] root = 32'h0000_8000;
        lat = 2; rdy_delay = 1;
        mem_clear();
        mem_put(l1_addr(root, vpn), 32'h0033_3001);
        mem_put(l2_addr(32'h0033_3001, vpn), 32'hABCDE00E);
        do_walk(vpn, root, 1'b0);
        chk("R6", "read count", req_count, 2);
        chk("R6", "second read address", req_log[1], l2_addr(32'h0033_3001, vpn));
        chk("R6", "res_fault", {31'h0, res_fault}, 32'h1);
        chk("R6", "res_ppn", {12'h0, res_ppn}, 32'h0);
        chk("R6", "perm", {29'h0, res_user, res_write, res_read}, 32'h0);
        take_result();
    endtask

    task automatic t_busy_hold();
        logic [19:0] vpn = 20'h55AA5;
        logic [31:0] root = 32'h0012_3000;
        logic [19:0] ppn0;
        int bad;
        lat = 4; rdy_delay = 0;
        mem_clear();
        mem_put(l1_addr(root, vpn), 32'h0007_7001);
        mem_put(l2_addr(32'h0007_7001, vpn), 32'h9876500B);
        do_walk(vpn, root, 1'b1);
        chk("R8", "miss_ready high while busy", poke_bad, 0);
        chk("R8", "res_vpn kept", {12'h0, res_vpn}, {12'h0, vpn});
        chk("R8", "read count", req_count, 2);
        chk("R12", "root sampled at acceptance", req_log[0], l1_addr(root, vpn));
        ppn0 = res_ppn;
        bad = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (!res_valid || res_ppn !== ppn0 || res_vpn !== vpn || !busy) bad++;
        end
        chk("R10", "result held while not accepted", bad, 0);
        chk("R9", "busy before handshake", {31'h0, busy}, 32'h1);
        take_result();
        chk("R9", "busy after handshake", {31'h0, busy}, 32'h0);
        chk("R9", "res_valid after handshake", {31'h0, res_valid}, 32'h0);
        chk("R8", "no extra walk", req_count, 2);
    endtask

    task automatic t_spurious();
        logic [19:0] vpn = 20'h2F0F0;
        logic [31:0] root = 32'h0050_0000;
        spur_data = 32'hFFFFF00F;
        spur_mode = 1;
        repeat (3) @(negedge clk);
        chk("R11", "idle stray: busy", {31'h0, busy}, 32'h0);
        chk("R11", "idle stray: res_valid", {31'h0, res_valid}, 32'h0);
        lat = 1; rdy_delay = 3;
        spur_data = 32'h11111001;
        spur_mode = 2;
        leaf_case(vpn, root, 32'h0044_4001, 32'h0BEEF007);
        chk("R11", "stray consumed", spur_mode, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        miss_valid = 1'b0;
        miss_vpn = '0;
        root_base = '0;
        res_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_leaf_walks();
        t_l1_fault();
        t_l2_fault();
        t_busy_hold();
        t_spurious();
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end
endmodule